// File: doc/BRIEF.md
# Reset Release and Clock-Startup Sequencer

This block turns a set of reset requests into a timed release of the system reset and of the system clock. Each request pulse starts a sequence. The sequence type depends on which request arrived: a power-up request, a supply-dip request, or one of six run-time requests (external pin, watchdog, software, bad opcode, uninitialized working register, trap conflict). The system reset is held through a chain of stages whose length depends on the request type. In parallel, a clock wait covers oscillator start-up and PLL settling for the selected oscillator class.

The block also chooses the oscillator code that the clock tree uses after the reset. It raises a ready flag once both the reset chain and the clock wait have finished. It arms the fail-safe clock monitor, after a hold-off where one applies. It keeps a one-hot record of the last accepted request, which can be cleared by write-one-to-clear. Every delay is a parameter counted in cycles of `clk`, the reference tick. The defaults assume a 1 MHz tick.

Top module: `rst_clk_sequencer`

## Requirements
- R1: A power-up request (`req_in` bit 0) holds `sys_rst_n` low for exactly `T_POR + T_START + T_RST` cycles, counted from the clock edge that samples the request. The stages run in the order power-up delay, start-up delay, internal-state delay.
- R2: A supply-dip request (`req_in` bit 1) holds `sys_rst_n` low for exactly `T_START + T_RST` cycles.
- R3: Any of the run-time requests (`req_in` bits 2 to 7) holds `sys_rst_n` low for exactly `T_RST` cycles, whatever the oscillator code.
- R4: `T_START` is `T_START_REG` when `vreg_en` is 1 and `T_START_NOREG` when it is 0. The value of `vreg_en` is sampled with the request.
- R5: For power-up and supply-dip requests, `sys_clk_en` stays low after the request for a wait that depends on the selected oscillator code:
  - codes 0, 5 and 6 (RC, low-power RC, external clock): none
  - codes 1 and 7 (RC or external clock with PLL): `T_LOCK`
  - codes 2 and 4 (crystal, secondary crystal): the start-up count
  - code 3 (crystal with PLL): the start-up count, then `T_LOCK`
- R6: The start-up count completes on the `OST_CYCLES`-th clock edge that sees `osc_tick` high. It runs alongside the reset chain, not after it.
- R7: `cpu_run` rises in the first cycle where both `sys_rst_n` and `sys_clk_en` are high, which is the later of the two release points.
- R8: `fscm_arm` rises one cycle after `sys_rst_n` rises, or `T_FSCM + 1` cycles after it when a power-up or supply-dip request selected a PLL or crystal code. It is low from every accepted request until then.
- R9: `clk_sel` takes `osc_cfg` when a power-up or supply-dip request is accepted, or when `clk_switch_en` is 0. Otherwise it takes `osc_cur`. It changes only when a request is accepted.
- R10: Simultaneous requests resolve to the lowest bit index. While a sequence is in progress (before `cpu_run`), a request is accepted and restarts the sequence only if its class ranks at or above the running class (power-up > supply-dip > run-time). Otherwise it is ignored.
- R11: `req_flags` holds exactly the bit of the last accepted request, using the `req_in` bit positions. A 1 in `req_clr` clears that flag bit. When a request is accepted in the same cycle as a clear, the new flag wins.
- R12: While `rst_n` is low, and afterwards until a request arrives, `sys_rst_n`, `sys_clk_en`, `cpu_run`, `fscm_arm` and `req_flags` are all 0.
- R13: A run-time request never drops `sys_clk_en` and never applies a monitor hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference tick clock |
| rst_n | input | 1 | Synchronous active-low reset of the block itself |
| req_in | input | 8 | Reset request pulses, bit 0 power-up, 1 supply-dip, 2 pin, 3 watchdog, 4 software, 5 bad opcode, 6 uninitialized register, 7 trap conflict |
| req_clr | input | 8 | Write-one-to-clear strobes for `req_flags` |
| osc_cfg | input | 3 | Configured oscillator code |
| osc_cur | input | 3 | Oscillator code currently running |
| clk_switch_en | input | 1 | Clock switching enabled |
| vreg_en | input | 1 | On-chip regulator enabled (selects start-up delay) |
| osc_tick | input | 1 | One pulse per oscillator period, for the start-up count |
| sys_rst_n | output | 1 | System reset, low while held |
| sys_clk_en | output | 1 | System clock enable |
| cpu_run | output | 1 | Code execution may start |
| fscm_arm | output | 1 | Fail-safe clock monitor may operate |
| clk_sel | output | 3 | Oscillator code used after the reset |
| req_flags | output | 8 | One-hot record of the last accepted request |

## Verification
The hardest situation to reach is a second request arriving partway through a running sequence. Whether it restarts the chains or is dropped depends on how its class ranks against the running one, and the result shows only in when `sys_rst_n` finally rises. The bench pulses a power-up request and, 30 cycles later, a watchdog request. It then checks that the release lands exactly where the first sequence would have put it. It also starts a supply-dip sequence and interrupts it with a power-up request, which must push the release a full power-up chain past the second pulse. A gapped `osc_tick` pattern, toggling every cycle, shows that the start-up count follows oscillator periods rather than reference ticks.

// File: rtl/rsq_pkg.sv
// Package: shared codes, stage encodings and oscillator-class helpers for the
// reset/clock sequencer. Assumes eight request sources with fixed bit positions.
package rsq_pkg;

    localparam int NREQ     = 8;
    localparam int RQ_POWER = 0;
    localparam int RQ_DIP   = 1;

    // Request class, ordered so that a larger value ranks higher.
    typedef enum logic [1:0] {
        K_RUN   = 2'd0,
        K_DIP   = 2'd1,
        K_POWER = 2'd2
    } req_kind_e;

    typedef logic [2:0] osc_code_t;

    localparam osc_code_t OSC_RC      = 3'd0;
    localparam osc_code_t OSC_RC_PLL  = 3'd1;
    localparam osc_code_t OSC_XTAL    = 3'd2;
    localparam osc_code_t OSC_XTALPLL = 3'd3;
    localparam osc_code_t OSC_SEC     = 3'd4;
    localparam osc_code_t OSC_LPRC    = 3'd5;
    localparam osc_code_t OSC_EXT     = 3'd6;
    localparam osc_code_t OSC_EXT_PLL = 3'd7;

    typedef enum logic [2:0] {
        D_HOLD, D_PWR, D_START, D_IRST, D_DONE
    } chain_st_e;

    typedef enum logic [1:0] {
        W_HOLD, W_OST, W_LOCK, W_DONE
    } wait_st_e;

    typedef enum logic [1:0] {
        F_WAIT, F_HOLD, F_ARMED
    } hold_st_e;

    function automatic logic osc_has_ost(osc_code_t c);
        return (c == OSC_XTAL) || (c == OSC_XTALPLL) || (c == OSC_SEC);
    endfunction

    function automatic logic osc_has_pll(osc_code_t c);
        return (c == OSC_RC_PLL) || (c == OSC_XTALPLL) || (c == OSC_EXT_PLL);
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rsq_req_arb.sv
// Request arbiter: picks the lowest-index active request, filters it against
// the class of a sequence still in progress, and keeps the one-hot flag record.
// Assumes requests are single-cycle pulses; ready_in marks end of a sequence.
module rsq_req_arb
    import rsq_pkg::*;
#(
    parameter int NR = NREQ
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NR-1:0] req_in,
    input  logic [NR-1:0] req_clr,
    input  logic          ready_in,
    output logic          start,
    output req_kind_e     start_kind,
    output logic [NR-1:0] flags
);

    logic [NR-1:0] pick_oh;
    logic          busy;
    req_kind_e     cur_kind;

    // Isolate the lowest set request bit (highest priority).
    assign pick_oh = req_in & (~req_in + 1'b1);

    // Map the chosen request to its class.
    always_comb begin
        if (pick_oh[RQ_POWER])    start_kind = K_POWER;
        else if (pick_oh[RQ_DIP]) start_kind = K_DIP;
        else                      start_kind = K_RUN;
    end

    // Accept when idle, or when the new class ranks at or above the running one.
    assign start = (|req_in) && (!busy || (start_kind >= cur_kind));

    // Track whether a sequence is in progress and which class started it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cur_kind <= K_RUN;
        end else if (start) begin
            busy     <= 1'b1;
            cur_kind <= start_kind;
        end else if (ready_in) begin
            busy     <= 1'b0;
        end
    end

    // One-hot record of the last accepted request, write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flags <= '0;
        else if (start) flags <= pick_oh;
        else            flags <= flags & ~req_clr;
    end

    AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags));                                                   // R11
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && |(req_clr & flags)) |=> ((flags & $past(req_clr)) == '0)); // R11

endmodule

// File: rtl/rsq_delay_chain.sv
// System reset delay chain: runs the power-up, start-up and internal-state
// stages that apply to the accepted request class, then releases.
// Assumes every delay parameter is at least 1 cycle.
module rsq_delay_chain
    import rsq_pkg::*;
#(
    parameter int T_POR         = 10,
    parameter int T_START_REG   = 20,
    parameter int T_START_NOREG = 64000,
    parameter int T_RST         = 20
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  req_kind_e start_kind,
    input  logic      vreg_en,
    output logic      sys_rel
);

    localparam int TMAX = imax(imax(T_POR, T_RST), imax(T_START_REG, T_START_NOREG));
    localparam int CW   = $clog2(TMAX + 1);

    chain_st_e       st;
    logic [CW-1:0]   cnt;
    logic            use_reg;

    function automatic logic [CW-1:0] start_len(logic r);
        return r ? CW'(T_START_REG - 1) : CW'(T_START_NOREG - 1);
    endfunction

    // Stage sequencer: load on request, count down, step to the next stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= D_HOLD;
            cnt     <= '0;
            use_reg <= 1'b1;
        end else if (start) begin
            use_reg <= vreg_en;
            case (start_kind)
                K_POWER: begin st <= D_PWR;   cnt <= CW'(T_POR - 1);   end
                K_DIP:   begin st <= D_START; cnt <= start_len(vreg_en); end
                default: begin st <= D_IRST;  cnt <= CW'(T_RST - 1);   end
            endcase
        end else begin
            case (st)
                D_PWR: begin
                    if (cnt == '0) begin st <= D_START; cnt <= start_len(use_reg); end
                    else cnt <= cnt - 1'b1;
                end
                D_START: begin
                    if (cnt == '0) begin st <= D_IRST; cnt <= CW'(T_RST - 1); end
                    else cnt <= cnt - 1'b1;
                end
                D_IRST: begin
                    if (cnt == '0) st <= D_DONE;
                    else cnt <= cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign sys_rel = (st == D_DONE);

    AST_REL_AFTER_IRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rel) |-> ($past(st) == D_IRST));                          // R3
    AST_START_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (st == D_START && $past(st) != D_START) |-> ($past(st) == D_PWR || $past(start))); // R1
    AST_IRST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (st == D_IRST && $past(st) != D_IRST) |-> ($past(st) == D_START || $past(start))); // R2

endmodule

// File: rtl/rsq_clk_wait.sv
// Clock wait: counts oscillator periods for start-up, then the PLL settle time,
// as the selected oscillator class requires. Runs independently of the reset
// chain. Assumes osc_tick is synchronous to clk, one pulse per period.
module rsq_clk_wait
    import rsq_pkg::*;
#(
    parameter int OST_CYCLES = 1024,
    parameter int T_LOCK     = 20
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  req_kind_e start_kind,
    input  osc_code_t sel,
    input  logic      osc_tick,
    output logic      clk_ok
);

    localparam int OW = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1;
    localparam int LW = $clog2(T_LOCK + 1);

    wait_st_e       st;
    logic [OW-1:0]  ost_cnt;
    logic [LW-1:0]  lock_cnt;
    logic           pll_next;

    // Wait sequencer: start-up count on ticks, then the lock countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= W_HOLD;
            ost_cnt  <= '0;
            lock_cnt <= '0;
            pll_next <= 1'b0;
        end else if (start) begin
            pll_next <= osc_has_pll(sel);
            ost_cnt  <= '0;
            lock_cnt <= LW'(T_LOCK - 1);
            if (start_kind == K_RUN)   st <= W_DONE;
            else if (osc_has_ost(sel)) st <= W_OST;
            else if (osc_has_pll(sel)) st <= W_LOCK;
            else                       st <= W_DONE;
        end else begin
            case (st)
                W_OST: begin
                    if (osc_tick) begin
                        if (ost_cnt == OW'(OST_CYCLES - 1)) st <= pll_next ? W_LOCK : W_DONE;
                        else ost_cnt <= ost_cnt + 1'b1;
                    end
                end
                W_LOCK: begin
                    if (lock_cnt == '0) st <= W_DONE;
                    else lock_cnt <= lock_cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign clk_ok = (st == W_DONE);

    AST_OST_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_OST && !osc_tick && !start) |=> (st == W_OST));            // R6
    AST_CLK_DROP_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_ok) |-> ($past(start) && $past(start_kind) != K_RUN));    // R13

endmodule

// File: rtl/rsq_fscm_hold.sv
// Monitor hold-off: after the system reset releases, arms the fail-safe clock
// monitor at once or after a hold-off, as latched with the request.
module rsq_fscm_hold
    import rsq_pkg::*;
#(
    parameter int T_FSCM = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic need_hold,
    input  logic sys_rel,
    output logic arm
);

    localparam int HW = $clog2(T_FSCM + 1);

    hold_st_e       st;
    logic [HW-1:0]  cnt;
    logic           need_q;

    // Hold-off sequencer: wait for release, optional countdown, then arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= F_WAIT;
            cnt    <= '0;
            need_q <= 1'b0;
        end else if (start) begin
            st     <= F_WAIT;
            need_q <= need_hold;
        end else begin
            case (st)
                F_WAIT: begin
                    if (sys_rel) begin
                        if (need_q) begin st <= F_HOLD; cnt <= HW'(T_FSCM - 1); end
                        else st <= F_ARMED;
                    end
                end
                F_HOLD: begin
                    if (cnt == '0) st <= F_ARMED;
                    else cnt <= cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign arm = (st == F_ARMED);

    AST_ARM_NEEDS_REL: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> sys_rel);                                                   // R8

endmodule

// File: rtl/rst_clk_sequencer.sv
// Top: reset release and clock start-up sequencer. Selects the post-reset
// oscillator, runs the reset chain and the clock wait in parallel, flags
// readiness and arms the clock monitor. All delays are in clk cycles.
module rst_clk_sequencer
    import rsq_pkg::*;
#(
    parameter int T_POR         = 10,
    parameter int T_START_REG   = 20,
    parameter int T_START_NOREG = 64000,
    parameter int T_RST         = 20,
    parameter int T_LOCK        = 20,
    parameter int T_FSCM        = 100,
    parameter int OST_CYCLES    = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] req_in,
    input  logic [7:0] req_clr,
    input  logic [2:0] osc_cfg,
    input  logic [2:0] osc_cur,
    input  logic       clk_switch_en,
    input  logic       vreg_en,
    input  logic       osc_tick,
    output logic       sys_rst_n,
    output logic       sys_clk_en,
    output logic       cpu_run,
    output logic       fscm_arm,
    output logic [2:0] clk_sel,
    output logic [7:0] req_flags
);

    logic      start;
    req_kind_e start_kind;
    osc_code_t sel_next;
    logic      need_hold;
    logic      sys_rel;
    logic      clk_ok;
    logic      ready;

    // Oscillator choice for the request being accepted.
    assign sel_next  = (!clk_switch_en || start_kind != K_RUN) ? osc_cfg : osc_cur;
    assign need_hold = (start_kind != K_RUN) && (osc_has_ost(sel_next) || osc_has_pll(sel_next));
    assign ready     = sys_rel & clk_ok;

    rsq_req_arb #(.NR(NREQ)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_in     (req_in),
        .req_clr    (req_clr),
        .ready_in   (ready),
        .start      (start),
        .start_kind (start_kind),
        .flags      (req_flags)
    );

    rsq_delay_chain #(
        .T_POR         (T_POR),
        .T_START_REG   (T_START_REG),
        .T_START_NOREG (T_START_NOREG),
        .T_RST         (T_RST)
    ) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_kind (start_kind),
        .vreg_en    (vreg_en),
        .sys_rel    (sys_rel)
    );

    rsq_clk_wait #(
        .OST_CYCLES (OST_CYCLES),
        .T_LOCK     (T_LOCK)
    ) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_kind (start_kind),
        .sel        (sel_next),
        .osc_tick   (osc_tick),
        .clk_ok     (clk_ok)
    );

    rsq_fscm_hold #(.T_FSCM(T_FSCM)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .need_hold (need_hold),
        .sys_rel   (sys_rel),
        .arm       (fscm_arm)
    );

    // Register the oscillator code on each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)     clk_sel <= OSC_RC;
        else if (start) clk_sel <= sel_next;
    end

    assign sys_rst_n  = sys_rel;
    assign sys_clk_en = clk_ok;
    assign cpu_run    = ready;

    AST_SEL_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(clk_sel));                                       // R9
    AST_ARM_NOT_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (fscm_arm && !start) |=> (fscm_arm || $past(start)) );              // R8

endmodule

// File: tb/tb_rst_clk_sequencer.sv
module tb_rst_clk_sequencer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req_in, req_clr;
    logic [2:0] osc_cfg, osc_cur;
    logic       clk_switch_en, vreg_en, osc_tick;
    logic       sys_rst_n, sys_clk_en, cpu_run, fscm_arm;
    logic [2:0] clk_sel;
    logic [7:0] req_flags;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rst_clk_sequencer dut (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .req_clr(req_clr),
        .osc_cfg(osc_cfg), .osc_cur(osc_cur), .clk_switch_en(clk_switch_en),
        .vreg_en(vreg_en), .osc_tick(osc_tick), .sys_rst_n(sys_rst_n),
        .sys_clk_en(sys_clk_en), .cpu_run(cpu_run), .fscm_arm(fscm_arm),
        .clk_sel(clk_sel), .req_flags(req_flags)
    );

    typedef struct packed {
        logic [2:0] src;
        logic [2:0] cfg;
        logic [2:0] cur;
        logic       swen;
        logic       vreg;
        int         e_sys;
        int         e_clk;
        int         e_arm;
        logic [2:0] e_sel;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{3'd0, 3'd0, 3'd0, 1'b0, 1'b1, 50,    0,  51, 3'd0},
        '{3'd0, 3'd1, 3'd4, 1'b1, 1'b1, 50,   20, 151, 3'd1},
        '{3'd0, 3'd2, 3'd0, 1'b0, 1'b1, 50, 1024, 151, 3'd2},
        '{3'd0, 3'd3, 3'd0, 1'b0, 1'b1, 50, 1044, 151, 3'd3},
        '{3'd0, 3'd5, 3'd0, 1'b0, 1'b1, 50,    0,  51, 3'd5},
        '{3'd1, 3'd4, 3'd0, 1'b0, 1'b1, 40, 1024, 141, 3'd4},
        '{3'd1, 3'd7, 3'd0, 1'b0, 1'b1, 40,   20, 141, 3'd7},
        '{3'd1, 3'd6, 3'd3, 1'b1, 1'b1, 40,    0,  41, 3'd6},
        '{3'd2, 3'd3, 3'd5, 1'b1, 1'b1, 20,    0,  21, 3'd5},
        '{3'd3, 3'd2, 3'd6, 1'b0, 1'b1, 20,    0,  21, 3'd2},
        '{3'd4, 3'd0, 3'd1, 1'b1, 1'b1, 20,    0,  21, 3'd1},
        '{3'd5, 3'd7, 3'd4, 1'b1, 1'b1, 20,    0,  21, 3'd4},
        '{3'd6, 3'd1, 3'd0, 1'b0, 1'b1, 20,    0,  21, 3'd1},
        '{3'd7, 3'd5, 3'd2, 1'b1, 1'b1, 20,    0,  21, 3'd2}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Apply configuration and a one-cycle request; returns at the negedge after the sampling edge.
    task automatic pulse(input logic [7:0] m, input logic [2:0] cfg, input logic [2:0] cur,
                         input logic swen, input logic vreg);
        @(negedge clk);
        osc_cfg = cfg; osc_cur = cur; clk_switch_en = swen; vreg_en = vreg;
        req_in = m;
        @(negedge clk);
        req_in = '0;
    endtask

    // Count cycles until each output first reads high.
    task automatic measure(input int limit, output int ts, output int tc, output int tr, output int ta);
        ts = -1; tc = -1; tr = -1; ta = -1;
        for (int c = 0; c < limit; c++) begin
            if (ts < 0 && sys_rst_n)  ts = c;
            if (tc < 0 && sys_clk_en) tc = c;
            if (tr < 0 && cpu_run)    tr = c;
            if (ta < 0 && fscm_arm)   ta = c;
            if (ts >= 0 && tc >= 0 && tr >= 0 && ta >= 0) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int ts, tc, tr, ta;
        vec_t v;
        rst_n = 1'b0; req_in = '0; req_clr = '0; osc_cfg = '0; osc_cur = '0;
        clk_switch_en = 1'b0; vreg_en = 1'b1; osc_tick = 1'b1;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", "sys_rst_n in reset", int'(sys_rst_n), 0);
        check("R12", "sys_clk_en in reset", int'(sys_clk_en), 0);
        check("R12", "req_flags in reset", int'(req_flags), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R12", "outputs idle after reset",
              int'({sys_rst_n, sys_clk_en, cpu_run, fscm_arm}), 0);
        check("R12", "flags idle after reset", int'(req_flags), 0);

        // Table walk: R1 R2 R3 R5 R7 R8 R9 R11 R13
        for (int i = 0; i < NV; i++) begin
            v = TBL[i];
            pulse(8'd1 << v.src, v.cfg, v.cur, v.swen, v.vreg);
            measure(5000, ts, tc, tr, ta);
            check(v.src == 0 ? "R1" : (v.src == 1 ? "R2" : "R3"), "reset release", ts, v.e_sys);
            check(v.src >= 2 ? "R13" : "R5", "clock release", tc, v.e_clk);
            check("R7", "run", tr, (v.e_sys > v.e_clk) ? v.e_sys : v.e_clk);
            check("R8", "monitor arm", ta, v.e_arm);
            check("R9", "clk_sel", int'(clk_sel), int'(v.e_sel));
            check("R11", "flags", int'(req_flags), int'(8'd1 << v.src));
        end

        // R11: clear of a clear bit has no effect, clear of the set bit empties
        @(negedge clk); req_clr = 8'h01;
        @(negedge clk); req_clr = 8'h00;
        check("R11", "unrelated clear", int'(req_flags), 8'h80);
        req_clr = 8'h80;
        @(negedge clk); req_clr = 8'h00;
        check("R11", "clear", int'(req_flags), 0);

        // R10: simultaneous requests pick the lowest index
        pulse(8'h09, 3'd0, 3'd0, 1'b0, 1'b1);
        check("R10", "simultaneous flags", int'(req_flags), 8'h01);
        measure(5000, ts, tc, tr, ta);
        check("R10", "simultaneous release", ts, 50);

        // R10: lower class during a power-up sequence is ignored
        pulse(8'h01, 3'd0, 3'd0, 1'b0, 1'b1);
        repeat (29) @(negedge clk);
        pulse(8'h08, 3'd0, 3'd0, 1'b0, 1'b1);
        measure(5000, ts, tc, tr, ta);
        check("R10", "ignored watchdog release", ts, 19);
        check("R10", "ignored watchdog flags", int'(req_flags), 8'h01);

        // R10: power-up restarts a supply-dip sequence
        pulse(8'h02, 3'd0, 3'd0, 1'b0, 1'b1);
        repeat (10) @(negedge clk);
        pulse(8'h01, 3'd0, 3'd0, 1'b0, 1'b1);
        measure(5000, ts, tc, tr, ta);
        check("R10", "restart release", ts, 50);
        check("R10", "restart flags", int'(req_flags), 8'h01);

        // R6: gapped oscillator ticks stretch the start-up count
        osc_tick = 1'b0;
        pulse(8'h01, 3'd2, 3'd0, 1'b0, 1'b1);
        tc = -1;
        for (int c = 0; c < 3000; c++) begin
            if (sys_clk_en) begin tc = c; break; end
            osc_tick = ~osc_tick;
            @(negedge clk);
        end
        check("R6", "gapped start-up count", tc, 2047);
        check("R6", "reset chain ran in parallel", int'(sys_rst_n), 1);
        osc_tick = 1'b1;
        measure(5000, ts, tc, tr, ta);

        // R4: regulator disabled selects the long start-up delay
        pulse(8'h01, 3'd0, 3'd0, 1'b0, 1'b0);
        measure(70000, ts, tc, tr, ta);
        check("R4", "long start-up release", ts, 64030);
        check("R4", "monitor after long release", ta, 64031);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule